// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

The block drives a pair of complementary pulse-width-modulated signals for a half-bridge or full-bridge power stage. A free-running timer advances on an instruction-cycle enable tick. It restarts when it equals the period value. The primary output covers the first part of each period, up to the duty value. The complementary output covers the remainder of the period.

Each output turns on later than its nominal point, by a programmable dead-band count of ticks. This keeps the two power switches from conducting at the same time. Turn-off edges are never delayed. If the dead-band count uses up an output's whole window, that output stays inactive for the full period.

Period, duty and dead-band inputs are captured into working registers only at a period boundary. Each output has its own direction bit. When the bit is set, the output is released: it is no longer driven and reads inactive.

Top module: `cpwm_db`

## Requirements
- R1: The timer advances by one only on a clock where `tick_i` is 1 and holds otherwise. When it equals the working period value P on a tick, it returns to 0, so one period lasts P+1 ticks.
- R2: With working duty D and dead-band B, the primary level is high (active-high) for timer phases t with B <= t < D. When D > P, the primary is high from phase B to the end of the period.
- R3: The complementary level is high for timer phases t with D+B <= t <= P.
- R4: The primary and complementary levels are never high in the same cycle.
- R5: When B >= D the primary stays low for the whole period. When D+B > P the complementary stays low for the whole period.
- R6: With B = 0, exactly one of the two levels is high in every cycle while the timer runs.
- R7: `period_i`, `duty_i` and `dead_i` are sampled only on the tick that ends a period. Changes at any other time have no effect until the next boundary.
- R8: When a direction bit is 1, the matching `drv_*_o` is 0 and the matching `pwm_*_o` is 0 in the same cycle. When the bit is 0, the pin is driven (`drv_*_o` = 1) and shows its level.
- R9: Reset clears the timer and the working values and holds both levels low. The first tick after reset only loads the inputs. Each output level is registered one clock behind the timer phase it reflects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle enable; the timer advances on it |
| period_i | input | 8 | Period value P (period lasts P+1 ticks) |
| duty_i | input | 8 | Duty value D: the tick at which the primary turns off |
| dead_i | input | 7 | Dead-band count B in ticks |
| dir_a_i | input | 1 | Primary direction bit; 1 releases the pin |
| dir_b_i | input | 1 | Complementary direction bit; 1 releases the pin |
| pwm_a_o | output | 1 | Primary drive level |
| drv_a_o | output | 1 | Primary pin is driven |
| pwm_b_o | output | 1 | Complementary drive level |
| drv_b_o | output | 1 | Complementary pin is driven |

## Verification
A wrong timer count or a missed wrap moves every later edge. The bench compares both levels in every cycle against its own phase model, so such an error shows within one period. A working value loaded at the wrong moment shifts a duty or dead-band edge. That shift appears in the first period after the change, and a directed check aims at the cycle just after a mid-period change. A bad dead-band comparison shows either as overlap, which an assertion catches in that same cycle, or as a wrong count of high cycles over whole periods.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned TMR_W_DEF = 8;
  localparam int unsigned DB_W_DEF  = 7;

  typedef enum logic {
    GATE_PRI = 1'b0,
    GATE_CMP = 1'b1
  } gate_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int unsigned TMR_W = cpwm_pkg::TMR_W_DEF,
  parameter int unsigned DB_W  = cpwm_pkg::DB_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TMR_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic [TMR_W-1:0] per_o,
  output logic [TMR_W-1:0] duty_o,
  output logic [DB_W-1:0]  dead_o,
  output logic             run_o
);
  logic [TMR_W-1:0] tmr_q, per_q, duty_q;
  logic [DB_W-1:0]  dead_q;
  logic             run_q;
  logic             wrap;

  assign wrap = tick_i && (tmr_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
      run_q  <= 1'b0;
    end else if (wrap) begin
      tmr_q  <= '0;
      per_q  <= period_i;
      duty_q <= duty_i;
      dead_q <= dead_i;
      run_q  <= 1'b1;
    end else if (tick_i) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign tmr_o  = tmr_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign dead_o = dead_q;
  assign run_o  = run_q;

  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= per_q);
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && tmr_q == per_q) |=> (tmr_q == '0));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tmr_q));
  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && tmr_q == per_q) |=> ($stable(per_q) && $stable(duty_q) && $stable(dead_q)));
endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate #(
  parameter int unsigned   TMR_W = cpwm_pkg::TMR_W_DEF,
  parameter int unsigned   DB_W  = cpwm_pkg::DB_W_DEF,
  parameter cpwm_pkg::gate_e KIND = cpwm_pkg::GATE_PRI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic [TMR_W-1:0] per_i,
  input  logic [TMR_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  output logic             act_o
);
  localparam int unsigned EXT_W = TMR_W + 2;

  logic [EXT_W-1:0] on_pt, off_pt, start_pt, t_ext;
  logic             hit, act_q;

  // turn-on point is delayed by the dead band, turn-off is not
  generate
    if (KIND == cpwm_pkg::GATE_PRI) begin : g_pri
      assign on_pt  = '0;
      assign off_pt = EXT_W'(duty_i);
    end else begin : g_cmp
      assign on_pt  = EXT_W'(duty_i);
      assign off_pt = EXT_W'(per_i) + EXT_W'(1);
    end
  endgenerate

  assign t_ext    = EXT_W'(tmr_i);
  assign start_pt = on_pt + EXT_W'(dead_i);
  assign hit      = run_i && (t_ext >= start_pt) && (t_ext < off_pt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= hit;
  end

  assign act_o = act_q;

  a_r9_idle_until_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !act_q);
endmodule

// File: rtl/cpwm_pad.sv
module cpwm_pad (
  input  logic dir_i,
  input  logic lvl_i,
  output logic pin_o,
  output logic drv_o
);
  assign drv_o = ~dir_i;
  assign pin_o = lvl_i & ~dir_i;
endmodule

// File: rtl/cpwm_db.sv
module cpwm_db #(
  parameter int unsigned TMR_W = cpwm_pkg::TMR_W_DEF,
  parameter int unsigned DB_W  = cpwm_pkg::DB_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TMR_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  input  logic             dir_a_i,
  input  logic             dir_b_i,
  output logic             pwm_a_o,
  output logic             drv_a_o,
  output logic             pwm_b_o,
  output logic             drv_b_o
);
  localparam int unsigned NPIN = 2;

  logic [TMR_W-1:0] tmr, per, duty;
  logic [DB_W-1:0]  dead;
  logic             run;
  logic [NPIN-1:0]  lvl, dir, pin, drv;

  cpwm_timebase #(.TMR_W(TMR_W), .DB_W(DB_W)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .period_i(period_i),
    .duty_i  (duty_i),
    .dead_i  (dead_i),
    .tmr_o   (tmr),
    .per_o   (per),
    .duty_o  (duty),
    .dead_o  (dead),
    .run_o   (run)
  );

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_out
      cpwm_gate #(
        .TMR_W(TMR_W),
        .DB_W (DB_W),
        .KIND (g == 0 ? cpwm_pkg::GATE_PRI : cpwm_pkg::GATE_CMP)
      ) u_gate (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .tmr_i (tmr),
        .per_i (per),
        .duty_i(duty),
        .dead_i(dead),
        .act_o (lvl[g])
      );
      cpwm_pad u_pad (
        .dir_i(dir[g]),
        .lvl_i(lvl[g]),
        .pin_o(pin[g]),
        .drv_o(drv[g])
      );
    end
  endgenerate

  assign dir     = {dir_b_i, dir_a_i};
  assign pwm_a_o = pin[0];
  assign pwm_b_o = pin[1];
  assign drv_a_o = drv[0];
  assign drv_b_o = drv[1];

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lvl[0] && lvl[1]));
  a_r2_late_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl[0]) |-> (int'($past(tmr)) >= int'($past(dead))));
  a_r3_after_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl[1]) |-> (int'($past(tmr)) >= int'($past(duty)) + int'($past(dead))));
  a_r8_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_a_i |-> (!pwm_a_o && !drv_a_o)) and (dir_b_i |-> (!pwm_b_o && !drv_b_o)));
endmodule

// File: tb/cpwm_db_tb.sv
`timescale 1ns/1ps
module cpwm_db_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] period = '0, duty = '0;
  logic [6:0] dead = '0;
  logic       dir_a = 1'b0, dir_b = 1'b0;
  logic       pwm_a, drv_a, pwm_b, drv_b;

  int    n_run = 0, n_fail = 0;
  string tag = "R9";
  int    tick_div = 1, tick_ph = 0;
  int    cnt_a = 0, cnt_b = 0;

  // phase model built from the requirements
  int m_t, m_p, m_d, m_db;
  bit m_run, e_a, e_b;

  always #4 clk = ~clk;

  cpwm_db u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .period_i(period), .duty_i(duty), .dead_i(dead),
    .dir_a_i(dir_a), .dir_b_i(dir_b),
    .pwm_a_o(pwm_a), .drv_a_o(drv_a), .pwm_b_o(pwm_b), .drv_b_o(drv_b)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_p = 0; m_d = 0; m_db = 0; m_run = 0; e_a = 0; e_b = 0;
    end else begin
      e_a = m_run && m_t >= m_db && m_t < m_d;
      e_b = m_run && m_t >= m_d + m_db && m_t <= m_p;
      if (tick) begin
        if (m_t == m_p) begin
          m_t = 0; m_p = period; m_d = duty; m_db = dead; m_run = 1;
        end else m_t++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    chk(tag, "pwm_a", pwm_a, e_a && !dir_a);
    chk(tag, "pwm_b", pwm_b, e_b && !dir_b);
    chk("R4", "overlap", pwm_a && pwm_b, 0);
    chk("R8", "drv_a", drv_a, !dir_a);
    chk("R8", "drv_b", drv_b, !dir_b);
    cnt_a += pwm_a;
    cnt_b += pwm_b;
    tick_ph++;
    tick = (tick_div != 0) && (tick_ph % tick_div == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_cfg(input int p, input int d, input int db);
    period = 8'(p); duty = 8'(d); dead = 7'(db);
  endtask

  task automatic measure(input string req, input int n, input int exp_a, input int exp_b);
    cnt_a = 0; cnt_b = 0;
    steps(n);
    chk(req, "high cycles a", cnt_a, exp_a);
    chk(req, "high cycles b", cnt_b, exp_b);
  endtask

  task automatic t_reset();
    tag = "R9";
    set_cfg(3, 2, 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R9", "pwm_a in reset", pwm_a, 0);
    chk("R9", "pwm_b in reset", pwm_b, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R9", "first tick loads only, a", pwm_a, 0);
    chk("R9", "first tick loads only, b", pwm_b, 0);
    step();
    chk("R9", "a on at phase 0", pwm_a, 1);
    steps(12);
  endtask

  task automatic t_basic();
    tag = "R2";
    set_cfg(9, 4, 2);
    steps(40);
    measure("R3", 30, 6, 12);
  endtask

  task automatic t_shadow();
    tag = "R7";
    while (!(pwm_a === 1'b1)) step();
    set_cfg(9, 8, 0);
    step();
    step();
    chk("R7", "old duty still in force", pwm_a, 0);
    steps(30);
    measure("R7", 20, 16, 4);
  endtask

  task automatic t_zero_dead();
    tag = "R6";
    set_cfg(7, 3, 0);
    steps(30);
    for (int i = 0; i < 16; i++) begin
      step();
      chk("R6", "exactly one active", pwm_a ^ pwm_b, 1);
    end
    measure("R6", 16, 6, 10);
  endtask

  task automatic t_dead_big();
    tag = "R5";
    set_cfg(9, 3, 5);
    steps(30);
    measure("R5", 30, 0, 6);
  endtask

  task automatic t_cmp_killed();
    tag = "R5";
    set_cfg(5, 4, 3);
    steps(30);
    measure("R5", 18, 3, 0);
  endtask

  task automatic t_full_duty();
    tag = "R2";
    set_cfg(9, 20, 1);
    steps(30);
    measure("R2", 30, 27, 0);
  endtask

  task automatic t_sparse();
    tag = "R1";
    tick_div = 3;
    set_cfg(5, 2, 1);
    steps(60);
    measure("R1", 54, 9, 27);
  endtask

  task automatic t_hold();
    logic a0, b0;
    tag = "R1";
    tick_div = 0;
    step();
    step();
    a0 = pwm_a; b0 = pwm_b;
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R1", "hold a", pwm_a, a0);
      chk("R1", "hold b", pwm_b, b0);
    end
    tick_div = 1;
    steps(4);
  endtask

  task automatic t_dir();
    tag = "R8";
    set_cfg(7, 3, 1);
    steps(20);
    dir_a = 1'b1;
    #1;
    chk("R8", "drv_a released at once", drv_a, 0);
    chk("R8", "pwm_a released at once", pwm_a, 0);
    measure("R8", 16, 0, 8);
    dir_a = 1'b0; dir_b = 1'b1;
    measure("R8", 16, 4, 0);
    dir_b = 1'b0;
    steps(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_shadow();
    t_zero_dead();
    t_dead_big();
    t_cmp_killed();
    t_full_duty();
    t_sparse();
    t_hold();
    t_dir();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule